// File: doc/BRIEF.md
# Indirect Management Register Bridge

This block is the device end of a serial management interface. It works on register-level read and write strobes; the serial bit framing is handled elsewhere. Behind it sits an internal register space of 32 devices with 32 registers each, 16 bits wide, held in a synchronous memory. A 5-bit address strap picks one of two ways to reach that space.

With the strap at zero the block is in direct mode. Every bus address selects the internal device of the same number, and the bus register number selects the register. With a nonzero strap the block responds only at the bus address equal to the strap. There it offers a command/status register and a data register. The host loads the data register, then writes a command word naming the device, the register and the operation. It then polls the busy flag. For a read, it collects the result from the data register once the flag drops.

A command is carried out once. The busy flag stays up for a fixed, parameterised number of cycles, well inside the host's budget of 16 status polls. Malformed commands, and commands or data loads that arrive while busy, leave no trace.

Top module: `smiBridge`

## Requirements
- R1: After reset, the command/status register (register 0 at the bridge address) reads 0x0000 and the data register (register 1) reads 0x0000.
- R2: With a strap of zero, a bus write to (bus address A, register N) stores the data at internal device A, register N. A bus read of the same pair returns that word with `busRvalid` high on the cycle after the read strobe, at any bus address.
- R3: With a nonzero strap, reads at any other bus address give `busRvalid` low, and writes at any other bus address change nothing.
- R4: At the bridge address, register 0 reads back as {busy, bits 14:0 of the last accepted command} and register 1 reads the data register. Every other register number reads 0xFFFF, and writes to it are ignored.
- R5: Command word layout: bit 12 must be 1; bits 11:10 are the opcode (2'b10 = read, 2'b01 = write); bits 9:5 are the internal device; bits 4:0 are the internal register. So 0x9800 ORed with the fields is a read and 0x9400 ORed with the fields is a write. Bit 15 reads as the busy flag.
- R6: An accepted write command stores the current data register value at the named internal register.
- R7: An accepted read command puts the named internal register's value in the data register before busy clears.
- R8: Busy is set by an accepted command and stays set for exactly BUSY_CYCLES clock cycles. Back-to-back status reads therefore see it set exactly BUSY_CYCLES times (4 by default), which is fewer than 16.
- R9: A command with bit 12 clear, or with opcode 2'b00 or 2'b11, is ignored: busy stays 0, the status word is unchanged and the memory is untouched.
- R10: A command written while busy is set is dropped and has no effect on the memory.
- R11: A data register write while busy is set is dropped.
- R12: Direct and indirect modes reach the same internal storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapAddr | input | 5 | Address strap; zero selects direct mode |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe |
| busPhy | input | 5 | Bus (device) address of the transaction |
| busReg | input | 5 | Register number of the transaction |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid with busRvalid |
| busRvalid | output | 1 | High one cycle after an answered read strobe |

## Verification
The bench reads the status word on every cycle right after a command and counts the busy readings. A design with an off-by-one busy counter shows one reading too many or too few. It sends malformed commands: bit 12 clear, and both unused opcodes. A decoder that checked only part of the word would raise busy or overwrite a register that was stored earlier. It sends a second command, and a data load, straight after an accepted command. A bridge without the busy guard would redirect the write or clobber the data register. It also moves data between direct and indirect mode, and addresses the bridge at other bus addresses, which exposes a wrong address decode or a separate store per mode.

// File: rtl/smiBridgePkg.sv
package smiBridgePkg;
  // opcode values in command bits 11:10
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptCmd;    // latch command word
    logic startWrite;   // write data register into memory
    logic startRead;    // issue memory read
    logic captureRead;  // memory output into data register
    logic loadData;     // host load of data register
  } ctrlStrobes_t;
endpackage

// File: rtl/smiBridgeRegFile.sv
module smiBridgeRegFile #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN)   rdata <= '0;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/smiBridgeCtrl.sv
module smiBridgeCtrl
  import smiBridgePkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              directMode,
  input  logic              bridgeHit,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busReg,
  input  logic [2:0]        cmdCtl,     // command bits 12:10
  output ctrlStrobes_t      strobes,
  output logic              busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] busyCnt;
  logic             rdPending;
  logic             bridgeWrite;
  logic             cmdWrite;
  logic             cmdValid;
  logic             accept;

  always_comb begin
    bridgeWrite = !directMode && busWe && bridgeHit;
    cmdWrite    = bridgeWrite && (busReg == '0);
    cmdValid    = cmdCtl[2] && ((cmdCtl[1:0] == OP_READ) || (cmdCtl[1:0] == OP_WRITE));
    accept      = cmdWrite && cmdValid && !busy;

    strobes.acceptCmd   = accept;
    strobes.startWrite  = accept && (cmdCtl[1:0] == OP_WRITE);
    strobes.startRead   = accept && (cmdCtl[1:0] == OP_READ);
    strobes.captureRead = rdPending;
    strobes.loadData    = bridgeWrite && (busReg == ADDR_W'(1)) && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      busyCnt   <= '0;
      rdPending <= 1'b0;
    end else begin
      rdPending <= strobes.startRead;
      if (accept) begin
        busy    <= 1'b1;
        busyCnt <= CNT_LOAD;
      end else if (busy) begin
        if (busyCnt == '0) busy <= 1'b0;
        else               busyCnt <= busyCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/smiBridgeDatapath.sv
module smiBridgeDatapath
  import smiBridgePkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              directMode,
  input  logic              bridgeHit,
  input  logic              busy,
  input  ctrlStrobes_t      strobes,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busPhy,
  input  logic [ADDR_W-1:0] busReg,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid
);
  localparam int MEM_AW = 2 * ADDR_W;

  logic [DATA_W-2:0] cmdQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] regRead;
  logic [DATA_W-1:0] rdRespQ;
  logic              fromMemQ;

  logic              memWe;
  logic              memRe;
  logic [MEM_AW-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata;

  // memory port: bus in direct mode, command fields otherwise
  always_comb begin
    if (directMode) begin
      memWe    = busWe;
      memRe    = busRe;
      memAddr  = {busPhy, busReg};
      memWdata = busWdata;
    end else begin
      memWe    = strobes.startWrite;
      memRe    = strobes.startRead;
      memAddr  = busWdata[MEM_AW-1:0];
      memWdata = dataQ;
    end
  end

  smiBridgeRegFile #(.AW(MEM_AW), .DW(DATA_W)) u_regFile (
    .clk   (clk),
    .rstN  (rstN),
    .we    (memWe),
    .re    (memRe),
    .addr  (memAddr),
    .wdata (memWdata),
    .rdata (memRdata)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= '0;
      dataQ <= '0;
    end else begin
      if (strobes.acceptCmd)   cmdQ  <= busWdata[DATA_W-2:0];
      if (strobes.captureRead) dataQ <= memRdata;
      else if (strobes.loadData) dataQ <= busWdata;
    end
  end

  always_comb begin
    if (busReg == '0)                regRead = {busy, cmdQ};
    else if (busReg == ADDR_W'(1))   regRead = dataQ;
    else                             regRead = '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdRespQ   <= '0;
      fromMemQ  <= 1'b0;
      busRvalid <= 1'b0;
    end else begin
      busRvalid <= busRe && (directMode || bridgeHit);
      fromMemQ  <= directMode;
      if (busRe && !directMode && bridgeHit) rdRespQ <= regRead;
    end
  end

  assign busRdata = fromMemQ ? memRdata : rdRespQ;
endmodule

// File: rtl/smiBridge.sv
module smiBridge
  import smiBridgePkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] strapAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busPhy,
  input  logic [ADDR_W-1:0] busReg,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid
);
  logic         directMode;
  logic         bridgeHit;
  logic         busy;
  ctrlStrobes_t strobes;

  assign directMode = (strapAddr == '0);
  assign bridgeHit  = (busPhy == strapAddr);

  smiBridgeCtrl #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .directMode (directMode),
    .bridgeHit  (bridgeHit),
    .busWe      (busWe),
    .busReg     (busReg),
    .cmdCtl     (busWdata[12:10]),
    .strobes    (strobes),
    .busy       (busy)
  );

  smiBridgeDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .directMode (directMode),
    .bridgeHit  (bridgeHit),
    .busy       (busy),
    .strobes    (strobes),
    .busWe      (busWe),
    .busRe      (busRe),
    .busPhy     (busPhy),
    .busReg     (busReg),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .busRvalid  (busRvalid)
  );
endmodule

// File: rtl/smiBridgeChecker.sv
module smiBridgeChecker
  import smiBridgePkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int BUSY_CYCLES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              directMode,
  input logic              bridgeHit,
  input logic              busWe,
  input logic              busRe,
  input logic [ADDR_W-1:0] busReg,
  input logic [2:0]        cmdCtl,
  input logic              busy,
  input ctrlStrobes_t      strobes,
  input logic              busRvalid
);
  logic [15:0] chkCnt;
  logic        cmdStrobe;
  logic        fmtOk;

  assign cmdStrobe = !directMode && busWe && bridgeHit && (busReg == '0);
  assign fmtOk     = cmdCtl[2] && (cmdCtl[1] ^ cmdCtl[0]);

  initial begin
    a_busy_param_r8: assert (BUSY_CYCLES >= 2);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !busy) chkCnt <= '0;
    else                chkCnt <= chkCnt + 16'd1;
  end

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && (chkCnt < 16'(BUSY_CYCLES - 1)) |=> busy);

  p_busy_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && (chkCnt == 16'(BUSY_CYCLES - 1)) |=> !busy);

  p_bad_cmd_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe && !fmtOk && !busy |=> !busy);

  p_drop_while_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe && busy |-> !strobes.acceptCmd && !strobes.startWrite);

  p_read_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureRead |-> busy);

  p_valid_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    busRvalid |-> $past(busRe) && ($past(directMode) || $past(bridgeHit)));
endmodule

bind smiBridge smiBridgeChecker #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .directMode (directMode),
  .bridgeHit  (bridgeHit),
  .busWe      (busWe),
  .busRe      (busRe),
  .busReg     (busReg),
  .cmdCtl     (busWdata[12:10]),
  .busy       (busy),
  .strobes    (strobes),
  .busRvalid  (busRvalid)
);

// File: tb/smiBridge_test.sv
module smiBridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_N     = 4;
  localparam logic [4:0] BRIDGE = 5'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  strapAddr = BRIDGE;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [4:0]  busPhy = '0;
  logic [4:0]  busReg = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busRvalid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] model [1024];
  bit          known [1024];

  always #(CLK_PERIOD / 2) clk = ~clk;

  smiBridge uut (
    .clk(clk), .rstN(rstN), .strapAddr(strapAddr), .busWe(busWe), .busRe(busRe),
    .busPhy(busPhy), .busReg(busReg), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid)
  );

  function automatic logic [15:0] mkCmd(input bit isRead, input logic [4:0] dev, input logic [4:0] rg);
    return (isRead ? 16'h9800 : 16'h9400) | {6'd0, dev, rg};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic busWrite(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    busWe = 1'b1; busPhy = phy; busReg = rg; busWdata = d;
    @(posedge clk); @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] phy, input logic [4:0] rg,
                         output logic [15:0] d, output logic v);
    busRe = 1'b1; busPhy = phy; busReg = rg;
    @(posedge clk); @(negedge clk);
    busRe = 1'b0;
    d = busRdata; v = busRvalid;
  endtask

  task automatic pollIdle();
    logic [15:0] d; logic v; bit done = 0;
    for (int i = 0; i < 16 && !done; i++) begin
      busRead(BRIDGE, 5'd0, d, v);
      if (!d[15]) done = 1;
    end
    if (!done) check("R8 timeout", 16'd1, 16'd0);
  endtask

  task automatic indWrite(input logic [4:0] dev, input logic [4:0] rg, input logic [15:0] d);
    busWrite(BRIDGE, 5'd1, d);
    busWrite(BRIDGE, 5'd0, mkCmd(0, dev, rg));
    pollIdle();
    model[{dev, rg}] = d; known[{dev, rg}] = 1;
  endtask

  task automatic indRead(input logic [4:0] dev, input logic [4:0] rg, output logic [15:0] d);
    logic v;
    busWrite(BRIDGE, 5'd0, mkCmd(1, dev, rg));
    pollIdle();
    busRead(BRIDGE, 5'd1, d, v);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    logic [15:0] d, st; logic v;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(BRIDGE, 5'd0, d, v); check("R1 status", d, 16'h0000);
    busRead(BRIDGE, 5'd1, d, v); check("R1 data", d, 16'h0000);

    // R4 unused registers
    busRead(BRIDGE, 5'd2, d, v);  check("R4 reg2", d, 16'hFFFF);
    busRead(BRIDGE, 5'd31, d, v); check("R4 reg31", d, 16'hFFFF);
    check("R4 valid", {15'd0, v}, 16'd1);
    busWrite(BRIDGE, 5'd2, 16'h4321);
    busRead(BRIDGE, 5'd1, d, v); check("R4 write ignored data", d, 16'h0000);
    busRead(BRIDGE, 5'd0, d, v); check("R4 write ignored status", d, 16'h0000);

    // R3 other bus addresses
    busRead(5'd6, 5'd0, d, v); check("R3 no answer", {15'd0, v}, 16'd0);
    busWrite(5'd6, 5'd1, 16'h1234);
    busWrite(5'd6, 5'd0, mkCmd(0, 5'd1, 5'd1));
    busRead(BRIDGE, 5'd1, d, v); check("R3 data untouched", d, 16'h0000);
    busRead(BRIDGE, 5'd0, d, v); check("R3 status untouched", d, 16'h0000);

    // R8 / R5 / R6 busy length and status layout
    busWrite(BRIDGE, 5'd1, 16'hBEEF);
    busWrite(BRIDGE, 5'd0, mkCmd(0, 5'd3, 5'd7));
    model[{5'd3, 5'd7}] = 16'hBEEF; known[{5'd3, 5'd7}] = 1;
    busRead(BRIDGE, 5'd0, st, v);
    check("R5 status while busy", st, mkCmd(0, 5'd3, 5'd7));
    n = st[15] ? 1 : 0;
    for (int i = 0; i < 12; i++) begin
      busRead(BRIDGE, 5'd0, d, v);
      if (d[15]) n++;
      else break;
    end
    check("R8 busy count", 16'(n), 16'(BUSY_N));
    check("R5 status idle", d, mkCmd(0, 5'd3, 5'd7) & 16'h7FFF);

    // R7 read back
    indRead(5'd3, 5'd7, d); check("R7 read", d, 16'hBEEF);

    // R9 malformed commands
    busRead(BRIDGE, 5'd0, st, v);
    busWrite(BRIDGE, 5'd1, 16'h1111);
    foreach (d[i]) ;
    for (int k = 0; k < 3; k++) begin
      logic [15:0] bad;
      bad = (k == 0) ? 16'h9C00 : (k == 1) ? 16'h9000 : 16'h8400;
      busWrite(BRIDGE, 5'd0, bad | {6'd0, 5'd3, 5'd7});
      busRead(BRIDGE, 5'd0, d, v);
      check("R9 ignored", d, st);
    end
    indRead(5'd3, 5'd7, d); check("R9 memory intact", d, 16'hBEEF);

    // R10 command while busy
    indWrite(5'd2, 5'd2, 16'h5555);
    busWrite(BRIDGE, 5'd1, 16'hAAAA);
    busWrite(BRIDGE, 5'd0, mkCmd(0, 5'd1, 5'd1));
    busWrite(BRIDGE, 5'd0, mkCmd(0, 5'd2, 5'd2));
    pollIdle();
    model[{5'd1, 5'd1}] = 16'hAAAA; known[{5'd1, 5'd1}] = 1;
    indRead(5'd2, 5'd2, d); check("R10 dropped cmd", d, 16'h5555);
    indRead(5'd1, 5'd1, d); check("R10 first cmd", d, 16'hAAAA);

    // R11 data load while busy
    busWrite(BRIDGE, 5'd1, 16'h0101);
    busWrite(BRIDGE, 5'd0, mkCmd(0, 5'd4, 5'd4));
    busWrite(BRIDGE, 5'd1, 16'h7777);
    pollIdle();
    model[{5'd4, 5'd4}] = 16'h0101; known[{5'd4, 5'd4}] = 1;
    busRead(BRIDGE, 5'd1, d, v); check("R11 data kept", d, 16'h0101);

    // random indirect traffic (R6, R7)
    for (int it = 0; it < 60; it++) begin
      logic [9:0] a;
      a = 10'($urandom);
      if ($urandom % 2) indWrite(a[9:5], a[4:0], 16'($urandom));
      else if (known[a]) begin
        indRead(a[9:5], a[4:0], d);
        check("R7 random read", d, model[a]);
      end
    end

    // direct mode (R2, R12)
    strapAddr = 5'd0;
    @(negedge clk);
    busRead(5'd3, 5'd7, d, v);
    check("R12 indirect->direct", d, model[{5'd3, 5'd7}]);
    check("R2 valid", {15'd0, v}, 16'd1);
    for (int it = 0; it < 40; it++) begin
      logic [9:0] a;
      a = 10'($urandom);
      if ($urandom % 2) begin
        model[a] = 16'($urandom); known[a] = 1;
        busWrite(a[9:5], a[4:0], model[a]);
      end else if (known[a]) begin
        busRead(a[9:5], a[4:0], d, v);
        check("R2 direct read", d, model[a]);
      end
    end
    busWrite(5'd9, 5'd20, 16'hC0DE);
    busRead(5'd9, 5'd20, d, v); check("R2 direct", d, 16'hC0DE);

    strapAddr = BRIDGE;
    @(negedge clk);
    indRead(5'd9, 5'd20, d); check("R12 direct->indirect", d, 16'hC0DE);

    finish();
  end
endmodule